// File: doc/BRIEF.md
# Section and Page Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a translation table held in ordinary memory. A requester hands it one address at a time, together with a read/write flag, over a valid/ready handshake. The block picks one of two table bases, fetches the first-level descriptor, and decodes it. Depending on the descriptor type it finishes at once or fetches one second-level entry. It then reports the physical address with the descriptor's domain and permission fields, or it reports a translation fault.

Address bits [31:20] select one of 4096 first-level descriptors, each covering 1 MB. A descriptor can be unmapped, a 1 MB section, a 16 MB supersection, or a pointer to a 256-entry table of 4 KB pages. A configurable count of leading address bits routes lookups to the second base register, so low and high halves of the space can use separate tables. When the global enable is low, no table is read and the output address equals the input address.

Descriptors are read through a plain read port. The block pulses a request with an address, and the memory answers with a data-valid pulse one or more cycles later.

Top module: `xlat_walker`

## Requirements
- R1: With `xlat_en` low when a request is accepted, `rsp_valid` rises in the very next cycle with `rsp_pa` equal to the request address, `rsp_domain` and `rsp_ap` zero, and no memory read is issued.
- R2: With split count N (`split_n`) equal to 0, the table base is `base0`. With N nonzero, the base is `base0` when virtual address bits [31:32-N] are all zero, and `base1` otherwise.
- R3: The first memory read of a translated request goes to {base[31:14], VA[31:20], 2'b00}.
- R4: A first-level descriptor with bits [1:0] = 00 ends the walk with a one-cycle `rsp_fault` after exactly one read.
- R5: A first-level descriptor with bits [1:0] = 10 or 11 and bit 18 clear is a section: `rsp_pa` = {desc[31:20], VA[19:0]}, after exactly one read.
- R6: A section descriptor with bit 18 set is a supersection: `rsp_pa` = {desc[31:24], VA[23:0]}.
- R7: A first-level descriptor with bits [1:0] = 01 triggers a second read at {desc[31:10], VA[19:12], 2'b00}. If that entry has bit 1 set, `rsp_pa` = {entry[31:12], VA[11:0]}; otherwise the walk faults.
- R8: `rsp_domain` carries first-level descriptor bits [8:5]. `rsp_ap` is {desc[15], desc[11:10]} for sections and supersections, and {entry[9], entry[5:4]} for small pages.
- R9: `req_ready` is high only when no request is in progress. `rsp_valid` and `rsp_fault` are one-cycle pulses that are never high together, and `req_ready` returns in the cycle after either pulse.
- R10: `rsp_write` returns the `req_write` value of the request being answered.
- R11: `mem_req` is a one-cycle pulse per fetch. The block waits any number of cycles (at least one) for `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low gives identity mapping |
| base0 | input | 32 | Table base for the low region, 16 KB aligned |
| base1 | input | 32 | Table base for the high region, 16 KB aligned |
| split_n | input | SPLIT_W | Count of leading VA bits that select the base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access type, 1 = write |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Translation succeeded (one cycle) |
| rsp_fault | output | 1 | Translation fault (one cycle) |
| rsp_pa | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain field of the first-level descriptor |
| rsp_ap | output | 3 | Access-permission bits |
| rsp_write | output | 1 | Access type of the answered request |

## Verification
A walk state that goes astray shows at the memory port first: a wrong read count, or a read address whose index bits do not match the request. It also shows within a few cycles as a response of the wrong kind, either a fault instead of a valid result or the reverse. A mis-decoded descriptor appears in the same response cycle as a physical address joined at the wrong bit boundary, or as domain and permission bits taken from the wrong word. A stuck state machine holds `req_ready` low, so the next request never completes. Random addresses, bases and split counts, run against hashed table contents, reach every descriptor type. Directed entries cover supersections, faulting page entries and both sides of the base split.

// File: rtl/xlat_pkg.sv
// Shared constants and types for the translation walker.
// Assumes 32-bit addresses and 32-bit descriptors.
package xlat_pkg;
    localparam int ADDR_W      = 32;
    localparam int L1_IDX_W    = 12;
    localparam int L2_IDX_W    = 8;
    localparam int PAGE_OFF_W  = 12;
    localparam int SEC_OFF_W   = ADDR_W - L1_IDX_W;       // 20
    localparam int SUPER_OFF_W = SEC_OFF_W + 4;           // 24
    localparam int L1_ALIGN_W  = L1_IDX_W + 2;            // 14
    localparam int L2_ALIGN_W  = L2_IDX_W + 2;            // 10
    localparam int DOM_W       = 4;
    localparam int AP_W        = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_SECTION,
        L1K_TABLE
    } l1_kind_t;
endpackage

// File: rtl/xlat_base_sel.sv
// Picks the table base from the leading virtual address bits and forms
// the first-level descriptor fetch address.
// Assumes both bases are aligned to the table size (16 KB).
module xlat_base_sel
    import xlat_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic [ADDR_W-1:0]  va,
    input  logic [ADDR_W-1:0]  base0,
    input  logic [ADDR_W-1:0]  base1,
    input  logic [SPLIT_W-1:0] split_n,
    output logic [ADDR_W-1:0]  l1_addr
);
    logic [ADDR_W-1:0] top_mask;
    logic              use_hi;
    logic [ADDR_W-1:0] base_sel;
    logic              unused_base;

    // Mark each address bit that belongs to the leading split_n bits.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign top_mask[i] = (ADDR_W - i) <= int'(split_n);
    end

    // Any set bit in the leading region selects the second base.
    assign use_hi   = |(va & top_mask);
    assign base_sel = use_hi ? base1 : base0;
    assign l1_addr  = {base_sel[ADDR_W-1:L1_ALIGN_W], va[ADDR_W-1:SEC_OFF_W], 2'b00};

    assign unused_base = ^{base0[L1_ALIGN_W-1:0], base1[L1_ALIGN_W-1:0]};
endmodule

// File: rtl/xlat_l1_dec.sv
// Decodes a first-level descriptor: fault, section/supersection mapping,
// or pointer to a second-level table.
// Assumes bits [1:0] give the type and bit 18 marks a supersection.
module xlat_l1_dec
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0]      desc,
    input  logic [SUPER_OFF_W-1:0] va_lo,
    output l1_kind_t               kind,
    output logic [ADDR_W-1:0]      pa,
    output logic [DOM_W-1:0]       dom,
    output logic [AP_W-1:0]        ap,
    output logic [ADDR_W-1:0]      l2_addr
);
    logic unused_desc;

    // Classify the descriptor and build the section address.
    always_comb begin
        unique case (desc[1:0])
            2'b00:   kind = L1K_FAULT;
            2'b01:   kind = L1K_TABLE;
            default: kind = L1K_SECTION;
        endcase
        if (desc[18]) begin
            pa = {desc[ADDR_W-1:SUPER_OFF_W], va_lo};
        end else begin
            pa = {desc[ADDR_W-1:SEC_OFF_W], va_lo[SEC_OFF_W-1:0]};
        end
    end

    assign dom     = desc[8:5];
    assign ap      = {desc[15], desc[11:10]};
    assign l2_addr = {desc[ADDR_W-1:L2_ALIGN_W], va_lo[SEC_OFF_W-1:PAGE_OFF_W], 2'b00};

    assign unused_desc = ^{desc[19], desc[17:16], desc[14:12], desc[9], desc[4:2]};
endmodule

// File: rtl/xlat_l2_dec.sv
// Decodes a second-level entry: a small page when bit 1 is set,
// otherwise a fault.
// Assumes 4 KB pages.
module xlat_l2_dec
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0]     entry,
    input  logic [PAGE_OFF_W-1:0] va_lo,
    output logic                  fault,
    output logic [ADDR_W-1:0]     pa,
    output logic [AP_W-1:0]       ap
);
    logic unused_entry;

    assign fault = ~entry[1];
    assign pa    = {entry[ADDR_W-1:PAGE_OFF_W], va_lo};
    assign ap    = {entry[9], entry[5:4]};

    assign unused_entry = ^{entry[11:10], entry[8:6], entry[3:2], entry[0]};
endmodule

// File: rtl/xlat_walker.sv
// Translation walker top: accepts one request at a time, fetches one or two
// descriptors over a pulse-request read port and reports a physical address
// or a fault as a one-cycle pulse.
// Assumes memory answers each mem_req with exactly one mem_rvalid, at least
// one cycle later, and that bases and split count are stable during a walk.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xlat_en,
    input  logic [ADDR_W-1:0]      base0,
    input  logic [ADDR_W-1:0]      base1,
    input  logic [SPLIT_W-1:0]     split_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_va,
    input  logic                   req_write,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_rvalid,
    input  logic [ADDR_W-1:0]      mem_rdata,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [ADDR_W-1:0]      rsp_pa,
    output logic [DOM_W-1:0]       rsp_domain,
    output logic [AP_W-1:0]        rsp_ap,
    output logic                   rsp_write
);
    walk_state_t         state;
    logic [ADDR_W-1:0]   va_q;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   pa_q;
    logic [DOM_W-1:0]    dom_q;
    logic [AP_W-1:0]     ap_q;

    logic [ADDR_W-1:0]   l1_addr;
    l1_kind_t            l1_kind;
    logic [ADDR_W-1:0]   l1_pa;
    logic [DOM_W-1:0]    l1_dom;
    logic [AP_W-1:0]     l1_ap;
    logic [ADDR_W-1:0]   l2_addr;
    logic                l2_fault;
    logic [ADDR_W-1:0]   l2_pa;
    logic [AP_W-1:0]     l2_ap;

    logic                accept;

    xlat_base_sel #(.SPLIT_W(SPLIT_W)) u_base_sel (
        .va      (req_va),
        .base0   (base0),
        .base1   (base1),
        .split_n (split_n),
        .l1_addr (l1_addr)
    );

    xlat_l1_dec u_l1_dec (
        .desc    (mem_rdata),
        .va_lo   (va_q[SUPER_OFF_W-1:0]),
        .kind    (l1_kind),
        .pa      (l1_pa),
        .dom     (l1_dom),
        .ap      (l1_ap),
        .l2_addr (l2_addr)
    );

    xlat_l2_dec u_l2_dec (
        .entry (mem_rdata),
        .va_lo (va_q[PAGE_OFF_W-1:0]),
        .fault (l2_fault),
        .pa    (l2_pa),
        .ap    (l2_ap)
    );

    assign accept = req_valid && req_ready;

    // Walk sequencer: request capture, descriptor fetches and result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            pa_q   <= '0;
            dom_q  <= '0;
            ap_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        va_q  <= req_va;
                        wr_q  <= req_write;
                        dom_q <= '0;
                        ap_q  <= '0;
                        if (xlat_en) begin
                            addr_q <= l1_addr;
                            state  <= ST_L1_REQ;
                        end else begin
                            pa_q  <= req_va;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_L1_REQ: state <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rvalid) begin
                        dom_q <= l1_dom;
                        unique case (l1_kind)
                            L1K_FAULT: state <= ST_FAULT;
                            L1K_TABLE: begin
                                addr_q <= l2_addr;
                                state  <= ST_L2_REQ;
                            end
                            default: begin
                                pa_q  <= l1_pa;
                                ap_q  <= l1_ap;
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_L2_REQ: state <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rvalid) begin
                        if (l2_fault) begin
                            state <= ST_FAULT;
                        end else begin
                            pa_q  <= l2_pa;
                            ap_q  <= l2_ap;
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign mem_addr   = addr_q;
    assign rsp_valid  = (state == ST_DONE);
    assign rsp_fault  = (state == ST_FAULT);
    assign rsp_pa     = pa_q;
    assign rsp_domain = dom_q;
    assign rsp_ap     = ap_q;
    assign rsp_write  = wr_q;

    // R9: success and fault never coincide
    p_excl_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    // R9: block is ready again right after a response
    p_ready_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rsp_fault) |=> req_ready);

    // R1: bypass answers next cycle with the unchanged address
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=> (rsp_valid && !mem_req && rsp_pa == $past(req_va)));

    // R3: first fetch follows acceptance and is indexed by VA[31:20]
    p_l1_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xlat_en) |=> (mem_req && mem_addr[13:2] == $past(req_va[31:20])));

    // R11: each fetch request lasts exactly one cycle
    p_memreq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xlat_en;
    logic [31:0] base0, base1;
    logic [2:0]  split_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_va;
    logic        req_write;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_domain;
    logic [2:0]  rsp_ap;
    logic        rsp_write;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] rd_log [0:1023];
    int          total_reads = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] cap_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_walker #(.SPLIT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .base0(base0), .base1(base1),
        .split_n(split_n), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_domain(rsp_domain),
        .rsp_ap(rsp_ap), .rsp_write(rsp_write)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A5A_1234;
    endfunction

    // Memory model: latency of 1 to 3 cycles after the request edge.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend     <= 1'b1;
            cnt      <= int'($urandom_range(1, 3));
            cap_addr <= mem_addr;
            rd_log[total_reads[9:0]] <= mem_addr;
            total_reads <= total_reads + 1;
        end else if (pend) begin
            if (cnt <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd(cap_addr);
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements.
    task automatic expect_walk(input logic [31:0] va, input logic en,
                               output bit e_fault, output logic [31:0] e_pa,
                               output logic [3:0] e_dom, output logic [2:0] e_ap,
                               output int e_reads, output logic [31:0] e_l1,
                               output logic [31:0] e_l2);
        logic [31:0] b, d, e;
        bit hi = 0;
        e_fault = 0; e_pa = va; e_dom = 0; e_ap = 0; e_reads = 0; e_l1 = 0; e_l2 = 0;
        if (!en) return;
        for (int k = 0; k < int'(split_n); k++) if (va[31-k]) hi = 1;   // R2
        b = hi ? base1 : base0;
        e_l1 = {b[31:14], va[31:20], 2'b00};                             // R3
        d = rd(e_l1);
        e_reads = 1;
        e_dom = d[8:5];
        if (d[1:0] == 2'b00) begin e_fault = 1; return; end               // R4
        if (d[1:0] == 2'b01) begin                                        // R7
            e_l2 = {d[31:10], va[19:12], 2'b00};
            e = rd(e_l2);
            e_reads = 2;
            if (!e[1]) begin e_fault = 1; return; end
            e_pa = {e[31:12], va[11:0]};
            e_ap = {e[9], e[5:4]};
            return;
        end
        e_ap = {d[15], d[11:10]};                                         // R8
        if (d[18]) e_pa = {d[31:24], va[23:0]};                           // R6
        else       e_pa = {d[31:20], va[19:0]};                           // R5
    endtask

    task automatic run_xlat(input logic [31:0] va, input logic wr, input logic en,
                            input string tag);
        bit e_fault; logic [31:0] e_pa, e_l1, e_l2; logic [3:0] e_dom; logic [2:0] e_ap;
        int e_reads, start, cyc;
        bit done = 0, busy_ok = 1;
        expect_walk(va, en, e_fault, e_pa, e_dom, e_ap, e_reads, e_l1, e_l2);
        @(negedge clk);
        start = total_reads;
        req_va = va; req_write = wr; xlat_en = en; req_valid = 1'b1;
        check(req_ready == 1'b1, "R9", {tag, " ready when idle"}, 32'(req_ready), 32'd1);
        @(posedge clk);
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (rsp_valid || rsp_fault) done = 1;
            else if (req_ready) busy_ok = 0;
        end
        check(done, "R9", {tag, " response arrives"}, 32'(cyc), 32'd40);
        check(busy_ok, "R9", {tag, " not ready while busy"}, 32'(busy_ok), 32'd1);
        check(!(rsp_valid && rsp_fault), "R9", {tag, " single response kind"},
              {rsp_valid, rsp_fault}, 32'd1);
        check(rsp_fault == e_fault, e_fault ? "R4" : "R5", {tag, " fault flag"},
              32'(rsp_fault), 32'(e_fault));
        check(total_reads - start == e_reads, "R11", {tag, " read count"},
              32'(total_reads - start), 32'(e_reads));
        if (e_reads >= 1)
            check(rd_log[start[9:0]] == e_l1, "R3", {tag, " first fetch address (R2 base)"},
                  rd_log[start[9:0]], e_l1);
        if (e_reads == 2)
            check(rd_log[start[9:0] + 10'd1] == e_l2, "R7", {tag, " second fetch address"},
                  rd_log[start[9:0] + 10'd1], e_l2);
        if (!e_fault) begin
            check(rsp_pa == e_pa, en ? "R5" : "R1", {tag, " physical address"}, rsp_pa, e_pa);
            check(rsp_domain == e_dom, "R8", {tag, " domain"}, 32'(rsp_domain), 32'(e_dom));
            check(rsp_ap == e_ap, "R8", {tag, " permissions"}, 32'(rsp_ap), 32'(e_ap));
            check(rsp_write == wr, "R10", {tag, " access type"}, 32'(rsp_write), 32'(wr));
        end
        if (!en) check(cyc == 1, "R1", {tag, " bypass latency"}, 32'(cyc), 32'd1);
        @(negedge clk);
        check(req_ready && !rsp_valid && !rsp_fault, "R9", {tag, " pulse ends, ready"},
              {req_ready, rsp_valid, rsp_fault}, 32'h4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] b0d;
        void'($urandom(32'd20200117));
        rst_n = 0; xlat_en = 0; base0 = 0; base1 = 0; split_n = 0;
        req_valid = 0; req_va = 0; req_write = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check(req_ready && !rsp_valid && !rsp_fault && !mem_req, "R9", "reset state",
              {req_ready, rsp_valid, rsp_fault, mem_req}, 32'h8);

        base0 = 32'h0004_0000; base1 = 32'h0010_0000; split_n = 0;
        b0d = 32'h0004_0000;
        // R5: section, type 10 and type 11
        mem_img[{b0d[31:14], 12'h123, 2'b00}] = 32'hABC0_8000 | 32'h0000_0800 | (32'h5 << 5) | 32'h2;
        run_xlat(32'h1234_5678, 1'b0, 1'b1, "R5 section");
        mem_img[{b0d[31:14], 12'h124, 2'b00}] = 32'h7770_0400 | (32'h3 << 5) | 32'h3;
        run_xlat(32'h124F_FFFF, 1'b1, 1'b1, "R5 section type 11");
        // R6: supersection
        mem_img[{b0d[31:14], 12'h3A1, 2'b00}] = 32'hC500_0000 | 32'h0004_0000 | 32'h0000_8C00 | (32'hF << 5) | 32'h2;
        run_xlat(32'h3A1C_DEF0, 1'b0, 1'b1, "R6 supersection");
        // R4: invalid
        mem_img[{b0d[31:14], 12'h200, 2'b00}] = 32'hFFFF_FFFC;
        run_xlat(32'h2000_0010, 1'b0, 1'b1, "R4 invalid");
        // R7: page table, valid page and faulting entry
        mem_img[{b0d[31:14], 12'h050, 2'b00}] = 32'h0080_0400 | (32'h9 << 5) | 32'h1;
        mem_img[{22'h0080_04 >> 2, 8'h34, 2'b00}] = 32'h0000_0000;
        mem_img[{32'h0080_0400 >> 10, 8'h34, 2'b00}[31:0]] = 32'hDEAD_B000 | 32'h200 | 32'h30 | 32'h2;
        mem_img[{32'h0080_0400 >> 10, 8'h35, 2'b00}[31:0]] = 32'hDEAD_C001;
        run_xlat(32'h0503_4ABC, 1'b1, 1'b1, "R7 small page");
        run_xlat(32'h0503_5ABC, 1'b0, 1'b1, "R7 page fault");
        // R2: split selects base1 when leading bits are not all zero
        split_n = 3'd1;
        run_xlat(32'h8765_4321, 1'b0, 1'b1, "R2 split 1 high");
        run_xlat(32'h1234_5678, 1'b0, 1'b1, "R2 split 1 low");
        split_n = 3'd4;
        run_xlat(32'h0FFF_0000, 1'b1, 1'b1, "R2 split 4 low");
        run_xlat(32'h1000_0000, 1'b1, 1'b1, "R2 split 4 high");
        split_n = 3'd0;
        run_xlat(32'hFFF0_0001, 1'b0, 1'b1, "R2 split 0 high VA");
        // R1: bypass
        run_xlat(32'hCAFE_F00D, 1'b1, 1'b0, "R1 bypass");
        run_xlat(32'h0000_0000, 1'b0, 1'b0, "R1 bypass zero");

        // Random mix over hashed tables
        for (int it = 0; it < 300; it++) begin
            base0   = $urandom;
            base1   = $urandom;
            split_n = 3'($urandom_range(0, 7));
            run_xlat($urandom, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0), "random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule